// File: doc/BRIEF.md
# High-Power Port Configuration Register

This block holds the per-port high-power enable bits of a four-port power-sourcing controller. It also keeps the side effects of those bits consistent. Each port has a 4-bit police threshold code, and the block stores those codes as well. When software sets a port's enable bit, the port's police code is reset to a fixed value. When software clears the bit, the code is set to a different fixed value. The enable bit also decides which current-limit fault time the port uses: a fixed nominal code, or a programmable code supplied from outside.

A port can also be turned on by the pushbutton, with the detected class reported as 4. In that case the block raises the enable bit and loads police code 0x8 without software help. It does this only inside a window of a few milliseconds that opens when inrush completes. The block also registers each port's fault-timer start condition. It gates the raised current-limit level so that it applies only after inrush has finished.

Software uses a small register bus. Address 0 is the mode byte. Addresses 1 and 2 each hold the police codes of two ports.

Top module: `hpwr_port_cfg`

## Requirements
- R1: Address 0 holds the port enables of ports 4..1 in bits 7..4 and a timing-compliance enable in bit 0. Bits 3..1 always read 0 and ignore writes. After reset the byte reads 0x00. Read data appears on `rd_data` one cycle after `bus_rd`.
- R2: When a write to address 0 changes a port's enable from 0 to 1, that port's police code becomes 0x0.
- R3: When a write to address 0 changes a port's enable from 1 to 0, that port's police code becomes 0xF. A port whose enable bit is unchanged keeps its police code.
- R4: With the enable bit clear, a port's `tlim_sel` equals the nominal code `TLIM_NOM`. With the bit set, `tlim_sel` equals that port's `tlim_prog` field. The output is registered.
- R5: The automatic update needs `pb_on` set and `det_cls` equal to 4 (3-bit code) while `inrush_done` is high and the window is open. On the first cycle these hold, the block sets the enable bit and loads police code 0x8. It does this once per rising edge of `inrush_done`. A port with `pb_on` low is never updated this way.
- R6: The window opens on the rising edge of `inrush_done` and closes after `WIN_MS` millisecond ticks. Conditions that first hold after the window has closed cause no update. Conditions that hold within the first `WIN_MS-1` ms do cause an update.
- R7: `flt_start` is set one cycle after `ilim_over` is high, or after `icut_over` is high with `icut_en` also high. Otherwise it is clear.
- R8: `ilim_boost` is high only when the enable bit is set and `inrush_done` is high, one cycle later. The enable bit never raises the limit before inrush is done.
- R9: A bus write to a police code in the same cycle as an automatic update wins for that code. The enable bit is still set by the update.
- R10: Address 1 holds the police code of port 2 in bits 7..4 and port 1 in bits 3..0. Address 2 holds port 4 and port 3 in the same way. All police codes reset to 0xF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| inrush_done | input | NPORT | Port has finished inrush |
| pb_on | input | NPORT | Port was turned on by the pushbutton |
| det_cls | input | 3*NPORT | Detected class per port |
| ilim_over | input | NPORT | Current-limit threshold exceeded |
| icut_over | input | NPORT | Cut threshold exceeded |
| icut_en | input | NPORT | Cut threshold enabled |
| tlim_prog | input | TLIM_W*NPORT | Programmable limit time per port |
| mode_en | output | NPORT | High-power enable per port |
| tpon_en | output | 1 | Timing-compliance enable |
| police | output | 4*NPORT | Police code per port |
| tlim_sel | output | TLIM_W*NPORT | Selected limit time per port |
| flt_start | output | NPORT | Fault-timer start per port |
| ilim_boost | output | NPORT | Raised current-limit level active |

## Verification
A stuck or wrongly updated enable bit shows on `tlim_sel` and `ilim_boost` one cycle after the bit changes. It also shows at the next read of address 0. A police code that misses its side effect shows at the next read of its address. A window counter that runs wrong shows only when a class-4 report arrives near the window edge. The bench therefore places a late and an early report, one on each side of the edge. Collision priority shows in the police code read back right after the colliding cycle.

// File: rtl/hpwr_cfg_pkg.sv
package hpwr_cfg_pkg;
  localparam int CLS_W = 3;
  localparam int POL_W = 4;
  localparam logic [POL_W-1:0] POL_ON_CODE   = 4'h0;
  localparam logic [POL_W-1:0] POL_OFF_CODE  = 4'hF;
  localparam logic [POL_W-1:0] POL_AUTO_CODE = 4'h8;
  localparam logic [CLS_W-1:0] CLS_HIGH      = 3'd4;
  localparam int POL_BASE_ADDR = 1;
endpackage

// File: rtl/hpwr_ms_tick.sv
module hpwr_ms_tick #(
  parameter int CLK_PER_MS = 200000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(CLK_PER_MS - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/hpwr_port_slice.sv
module hpwr_port_slice
  import hpwr_cfg_pkg::*;
#(
  parameter int WIN_MS   = 5,
  parameter int TLIM_W   = 4,
  parameter logic [TLIM_W-1:0] TLIM_NOM = 4'h3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ms_tick,
  input  logic              mode_wr,
  input  logic              mode_wbit,
  input  logic              pol_wr,
  input  logic [POL_W-1:0]  pol_wdata,
  input  logic              inrush_done,
  input  logic              pb_on,
  input  logic [CLS_W-1:0]  det_cls,
  input  logic              ilim_over,
  input  logic              icut_over,
  input  logic              icut_en,
  input  logic [TLIM_W-1:0] tlim_prog,
  output logic              mode,
  output logic [POL_W-1:0]  police,
  output logic [TLIM_W-1:0] tlim_sel,
  output logic              flt_start,
  output logic              ilim_boost
);
  localparam int MW = (WIN_MS > 1) ? $clog2(WIN_MS + 1) : 1;

  logic          inrush_q;
  logic          win_open;
  logic [MW-1:0] ms_cnt;
  logic          rise;
  logic          auto_go;
  logic          turn_on;
  logic          turn_off;

  assign rise     = inrush_done & ~inrush_q;
  assign auto_go  = (win_open | rise) & inrush_done & pb_on & (det_cls == CLS_HIGH);
  assign turn_on  = mode_wr &  mode_wbit & ~mode;
  assign turn_off = mode_wr & ~mode_wbit &  mode;

  // Automatic-update window, counted in millisecond ticks from inrush end
  always_ff @(posedge clk) begin
    if (rst) begin
      inrush_q <= 1'b0;
      win_open <= 1'b0;
      ms_cnt   <= '0;
    end else begin
      inrush_q <= inrush_done;
      if (!inrush_done || auto_go) begin
        win_open <= 1'b0;
        ms_cnt   <= '0;
      end else if (rise) begin
        win_open <= 1'b1;
        ms_cnt   <= '0;
      end else if (win_open && ms_tick) begin
        if (ms_cnt == MW'(WIN_MS - 1)) begin
          win_open <= 1'b0;
          ms_cnt   <= '0;
        end else begin
          ms_cnt <= ms_cnt + 1'b1;
        end
      end
    end
  end

  // Enable bit: bus write wins over the automatic update
  always_ff @(posedge clk) begin
    if (rst)          mode <= 1'b0;
    else if (mode_wr) mode <= mode_wbit;
    else if (auto_go) mode <= 1'b1;
  end

  // Police code: bus write, then enable-edge side effect, then auto load
  always_ff @(posedge clk) begin
    if (rst)                      police <= POL_OFF_CODE;
    else if (pol_wr)              police <= pol_wdata;
    else if (turn_on)             police <= POL_ON_CODE;
    else if (turn_off)            police <= POL_OFF_CODE;
    else if (auto_go && !mode_wr) police <= POL_AUTO_CODE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tlim_sel   <= TLIM_NOM;
      flt_start  <= 1'b0;
      ilim_boost <= 1'b0;
    end else begin
      tlim_sel   <= mode ? tlim_prog : TLIM_NOM;
      flt_start  <= ilim_over | (icut_en & icut_over);
      ilim_boost <= mode & inrush_done;
    end
  end
endmodule

// File: rtl/hpwr_port_cfg.sv
module hpwr_port_cfg
  import hpwr_cfg_pkg::*;
#(
  parameter int NPORT      = 4,
  parameter int ADDR_W     = 2,
  parameter int TLIM_W     = 4,
  parameter logic [TLIM_W-1:0] TLIM_NOM = 4'h3,
  parameter int WIN_MS     = 5,
  parameter int CLK_PER_MS = 200000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [7:0]               bus_wdata,
  output logic [7:0]               rd_data,
  input  logic [NPORT-1:0]         inrush_done,
  input  logic [NPORT-1:0]         pb_on,
  input  logic [CLS_W*NPORT-1:0]   det_cls,
  input  logic [NPORT-1:0]         ilim_over,
  input  logic [NPORT-1:0]         icut_over,
  input  logic [NPORT-1:0]         icut_en,
  input  logic [TLIM_W*NPORT-1:0]  tlim_prog,
  output logic [NPORT-1:0]         mode_en,
  output logic                     tpon_en,
  output logic [POL_W*NPORT-1:0]   police,
  output logic [TLIM_W*NPORT-1:0]  tlim_sel,
  output logic [NPORT-1:0]         flt_start,
  output logic [NPORT-1:0]         ilim_boost
);
  localparam int PAD_W     = 8 - 1 - NPORT;
  localparam int POL_PER_B = 8 / POL_W;
  localparam int MODE_LSB  = 8 - NPORT;

  logic       ms_tick;
  logic       mode_wr;
  logic [7:0] rd_next;

  assign mode_wr = bus_wr && (bus_addr == ADDR_W'(0));

  hpwr_ms_tick #(.CLK_PER_MS(CLK_PER_MS)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(ms_tick)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam int PADDR = POL_BASE_ADDR + p / POL_PER_B;
    localparam int PLSB  = (p % POL_PER_B) * POL_W;
    logic pol_wr;
    assign pol_wr = bus_wr && (bus_addr == ADDR_W'(PADDR));

    hpwr_port_slice #(
      .WIN_MS  (WIN_MS),
      .TLIM_W  (TLIM_W),
      .TLIM_NOM(TLIM_NOM)
    ) u_slice (
      .clk        (clk),
      .rst        (rst),
      .ms_tick    (ms_tick),
      .mode_wr    (mode_wr),
      .mode_wbit  (bus_wdata[MODE_LSB + p]),
      .pol_wr     (pol_wr),
      .pol_wdata  (bus_wdata[PLSB +: POL_W]),
      .inrush_done(inrush_done[p]),
      .pb_on      (pb_on[p]),
      .det_cls    (det_cls[p*CLS_W +: CLS_W]),
      .ilim_over  (ilim_over[p]),
      .icut_over  (icut_over[p]),
      .icut_en    (icut_en[p]),
      .tlim_prog  (tlim_prog[p*TLIM_W +: TLIM_W]),
      .mode       (mode_en[p]),
      .police     (police[p*POL_W +: POL_W]),
      .tlim_sel   (tlim_sel[p*TLIM_W +: TLIM_W]),
      .flt_start  (flt_start[p]),
      .ilim_boost (ilim_boost[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)          tpon_en <= 1'b0;
    else if (mode_wr) tpon_en <= bus_wdata[0];
  end

  always_comb begin
    rd_next = '0;
    if (bus_addr == ADDR_W'(0)) begin
      rd_next = {mode_en, {PAD_W{1'b0}}, tpon_en};
    end else begin
      for (int p = 0; p < NPORT; p++) begin
        if (bus_addr == ADDR_W'(POL_BASE_ADDR + p / POL_PER_B))
          rd_next[(p % POL_PER_B)*POL_W +: POL_W] = police[p*POL_W +: POL_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (bus_rd) rd_data <= rd_next;
  end
endmodule

// File: rtl/hpwr_port_cfg_chk.sv
module hpwr_port_cfg_chk #(
  parameter int NPORT  = 4,
  parameter int ADDR_W = 2,
  parameter int TLIM_W = 4,
  parameter logic [TLIM_W-1:0] TLIM_NOM = 4'h3
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    bus_wr,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic [7:0]              bus_wdata,
  input logic [NPORT-1:0]        inrush_done,
  input logic [NPORT-1:0]        ilim_over,
  input logic [NPORT-1:0]        icut_over,
  input logic [NPORT-1:0]        icut_en,
  input logic [NPORT-1:0]        mode_en,
  input logic [4*NPORT-1:0]      police,
  input logic [TLIM_W*NPORT-1:0] tlim_sel,
  input logic [NPORT-1:0]        flt_start,
  input logic [NPORT-1:0]        ilim_boost
);
  localparam int ML = 8 - NPORT;

  p_mode_wr_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(0)) |=> (mode_en == $past(bus_wdata[7:ML])));

  for (genvar p = 0; p < NPORT; p++) begin : g_chk
    localparam int PA = 1 + p / 2;
    localparam int PL = (p % 2) * 4;

    p_pol_on_r2: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == ADDR_W'(0) && bus_wdata[ML+p] && !mode_en[p])
      |=> (police[p*4 +: 4] == 4'h0));

    p_pol_off_r3: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == ADDR_W'(0) && !bus_wdata[ML+p] && mode_en[p])
      |=> (police[p*4 +: 4] == 4'hF));

    p_tlim_nom_r4: assert property (@(posedge clk) disable iff (rst)
      !mode_en[p] |=> (tlim_sel[p*TLIM_W +: TLIM_W] == TLIM_NOM));

    p_flt_set_r7: assert property (@(posedge clk) disable iff (rst)
      (ilim_over[p] || (icut_en[p] && icut_over[p])) |=> flt_start[p]);

    p_flt_clr_r7: assert property (@(posedge clk) disable iff (rst)
      !(ilim_over[p] || (icut_en[p] && icut_over[p])) |=> !flt_start[p]);

    p_boost_gate_r8: assert property (@(posedge clk) disable iff (rst)
      !inrush_done[p] |=> !ilim_boost[p]);

    p_pol_wr_r9: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == ADDR_W'(PA)) |=> (police[p*4 +: 4] == $past(bus_wdata[PL +: 4])));
  end
endmodule

bind hpwr_port_cfg hpwr_port_cfg_chk #(
  .NPORT(NPORT), .ADDR_W(ADDR_W), .TLIM_W(TLIM_W), .TLIM_NOM(TLIM_NOM)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .inrush_done(inrush_done), .ilim_over(ilim_over), .icut_over(icut_over),
  .icut_en(icut_en), .mode_en(mode_en), .police(police), .tlim_sel(tlim_sel),
  .flt_start(flt_start), .ilim_boost(ilim_boost)
);

// File: tb/hpwr_port_cfg_tb.sv
`timescale 1ns/1ps
module hpwr_port_cfg_tb;
  localparam int N   = 4;
  localparam int CPM = 40;
  localparam int WIN = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 0, bus_rd = 0;
  logic [1:0]    bus_addr = 0;
  logic [7:0]    bus_wdata = 0;
  logic [7:0]    rd_data;
  logic [N-1:0]  inrush_done = 0, pb_on = 0, ilim_over = 0, icut_over = 0, icut_en = 0;
  logic [3*N-1:0] det_cls = 0;
  logic [4*N-1:0] tlim_prog = 0;
  logic [N-1:0]  mode_en, flt_start, ilim_boost;
  logic          tpon_en;
  logic [4*N-1:0] police, tlim_sel;

  int checks = 0, fails = 0;
  bit done = 0;
  logic rd_seen = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  hpwr_port_cfg #(.TLIM_NOM(4'h3), .WIN_MS(WIN), .CLK_PER_MS(CPM)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .inrush_done(inrush_done), .pb_on(pb_on),
    .det_cls(det_cls), .ilim_over(ilim_over), .icut_over(icut_over), .icut_en(icut_en),
    .tlim_prog(tlim_prog), .mode_en(mode_en), .tpon_en(tpon_en), .police(police),
    .tlim_sel(tlim_sel), .flt_start(flt_start), .ilim_boost(ilim_boost)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: pops the scoreboard for each completed read
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, {24'h0, rd_data}, {24'h0, e});
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 0;
    @(negedge clk);
    // R1 / R10 reset state
    rd(2'd0, 8'h00, "R1 reset mode byte");
    rd(2'd1, 8'hFF, "R10 reset police p2p1");
    rd(2'd2, 8'hFF, "R10 reset police p4p3");
    // R1 unused bits, R2 enable rising side effect
    wr(2'd0, 8'hFF);
    rd(2'd0, 8'hF1, "R1 unused bits read zero");
    rd(2'd1, 8'h00, "R2 police on p2p1");
    rd(2'd2, 8'h00, "R2 police on p4p3");
    // R3 enable falling side effect
    wr(2'd1, 8'h5A);
    wr(2'd2, 8'hC3);
    wr(2'd0, 8'h01);
    rd(2'd1, 8'hFF, "R3 police off p2p1");
    rd(2'd2, 8'hFF, "R3 police off p4p3");
    rd(2'd0, 8'h01, "R1 tpon only");
    // R2 single port
    wr(2'd0, 8'h21);
    rd(2'd1, 8'h0F, "R2 port2 only");
    // R3 unchanged bit keeps code
    wr(2'd1, 8'h37);
    wr(2'd0, 8'h21);
    rd(2'd1, 8'h37, "R3 no transition keeps code");
    // R4 limit time select
    tlim_prog = 16'hDCBA;
    idle(2);
    chk("R4 tlim select", {16'h0, tlim_sel}, 32'h33B3);
    // R7 fault-timer start
    ilim_over = 4'b0001; icut_over = 4'b0110; icut_en = 4'b0100;
    idle(1);
    chk("R7 flt start mix", {28'h0, flt_start}, 32'h5);
    ilim_over = 0; icut_over = 4'b0110; icut_en = 0;
    idle(1);
    chk("R7 cut disabled", {28'h0, flt_start}, 32'h0);
    icut_over = 0;
    // R8 boost gated by inrush
    idle(1);
    chk("R8 boost before inrush", {28'h0, ilim_boost}, 32'h0);
    inrush_done[1] = 1;
    idle(1);
    chk("R8 boost after inrush", {28'h0, ilim_boost}, 32'h2);
    // R5 automatic update on port3
    wr(2'd0, 8'h00);
    pb_on[2] = 1; det_cls[8:6] = 3'd4; inrush_done[2] = 1;
    @(negedge clk);
    rd(2'd0, 8'h40, "R5 auto sets enable");
    rd(2'd2, 8'hF8, "R5 auto police code");
    wr(2'd2, 8'hF3);
    idle(20);
    rd(2'd2, 8'hF3, "R5 applied once");
    // R5 no pushbutton, port1
    det_cls[2:0] = 3'd4; inrush_done[0] = 1;
    idle(5);
    rd(2'd0, 8'h40, "R5 no pushbutton no update");
    // R6 late class on port4
    pb_on[3] = 1; det_cls[11:9] = 3'd3; inrush_done[3] = 1;
    idle(WIN * CPM + 10);
    det_cls[11:9] = 3'd4;
    idle(5);
    rd(2'd0, 8'h40, "R6 late class no update");
    // R6 early class on port2
    inrush_done[1] = 0;
    idle(2);
    pb_on[1] = 1; det_cls[5:3] = 3'd2; inrush_done[1] = 1;
    idle(2 * CPM);
    det_cls[5:3] = 3'd4;
    idle(2);
    rd(2'd0, 8'h60, "R6 class inside window");
    rd(2'd1, 8'h87, "R6 police after update");
    // R9 bus write collides with auto update on port4
    inrush_done[3] = 0;
    idle(2);
    inrush_done[3] = 1;
    wr(2'd2, 8'h9C);
    rd(2'd2, 8'h9C, "R9 bus write wins police");
    rd(2'd0, 8'hE0, "R9 enable still set");
    idle(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule